// File: doc/BRIEF.md
# RTC Windowed Register Access Controller

This block is the host-facing register front end of a real-time clock and calendar. The host sees two 16-bit registers. The first is a configuration and calibration word. It carries the module enable, a write-unlock bit, two read-only status flags (update-in-progress and second half of the second), an output enable, a 2-bit window pointer and an 8-bit calibration byte. The second is a single value register. The window pointer chooses which pair of time or date fields appears in it.

Every read strobe or write strobe on the value register steps the window pointer down by one until it reaches zero. The host can therefore set the pointer once and then walk through year, month and day, weekday and hour, and minutes and seconds with back-to-back accesses. Writes to the time fields and to the enable bit are accepted only while the unlock bit is set.

A small BCD time counter lives behind the window so that the status flags behave realistically. It is fed by a prescaler that counts tick-enable pulses. The calibration byte is stored and read back only; it is not applied to the timebase.

Top module: `rtc_win_regs`

## Requirements
- R1: Each cycle with `val_rd` or `val_wr` high (and no `cfg_wr`) lowers the window pointer (config bits 9:8) by one. At 0 it stays at 0. A config write in the same cycle sets the pointer instead.
- R2: `val_rdata` shows, by pointer value: 0 gives {minutes, seconds}; 1 gives {weekday, hours}; 2 gives {month, day}; 3 gives {8'h00, year}. Every field is one byte.
- R3: While the unlock bit (config bit 13) is 0, value writes change no time field, but the pointer still steps. While it is 1, a write stores both bytes into the selected pair. At pointer 3 only the low byte is stored (as the year) and the upper byte is dropped.
- R4: A config write changes the enable bit (config bit 15) only if the unlock bit is already 1 before that write. All other writable fields are updated either way.
- R5: Config layout: bit 15 enable, bit 14 reads 0, bit 13 unlock, bit 12 update-in-progress (read-only), bit 11 half-second (read-only), bit 10 output enable, bits 9:8 pointer, bits 7:0 calibration. Writes to bits 14, 12 and 11 have no effect.
- R6: Half-second reads 1 while the prescaler count is at least TICKS_PER_SEC/2, otherwise 0. An accepted value write at pointer 0 restarts the prescaler at 0, which clears it.
- R7: Update-in-progress reads 1 while enabled with the prescaler count at least TICKS_PER_SEC-SYNC_TICKS. It also reads 1 during the cycle in which the pending one-second update is applied, and reads 0 otherwise.
- R8: While enabled, every TICKS_PER_SEC ticks advance seconds by one, two cycles after the last tick. Seconds and minutes wrap from BCD 59 to 00 with a carry. Hours wrap from BCD 23 to 00 and advance the weekday, which wraps from 6 to 0. While disabled, neither the time nor the prescaler changes.
- R9: An accepted value write in the same cycle as the one-second update wins. That update is dropped for all fields.
- R10: `por_n` clears the config register and all time state. `rst_n` clears time and prescaler state but leaves the config register unchanged.
- R11: `sec_out` equals output enable AND half-second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| rst_n | input | 1 | System reset, asynchronous, active low |
| tick_en | input | 1 | Timebase tick enable, one pulse per tick |
| cfg_wr | input | 1 | Config register write strobe |
| cfg_wdata | input | 16 | Config write data |
| cfg_rdata | output | 16 | Config register read data |
| val_rd | input | 1 | Value register read strobe (steps pointer) |
| val_wr | input | 1 | Value register write strobe |
| val_wdata | input | 16 | Value write data |
| val_rdata | output | 16 | Value register read data for the current pointer |
| sec_out | output | 1 | Half-second square wave when output enable is set |

## Verification
A host write to the minutes/seconds pair can land in the same cycle as the one-second cascade update. The bench provokes this by running exactly one second of ticks and confirming that the update cycle has arrived: update-in-progress reads 1 while half-second reads 0. In that cycle it drives the value write. It judges the result by reading back exactly the written value rather than value plus one, and then by seeing a normal increment one full second later, since the write restarts the prescaler. The bench also lines up config writes with the pointer step of a value access, so that the config write is seen to take precedence.

// File: rtl/rtc_win_pkg.sv
package rtc_win_pkg;

  typedef enum logic [1:0] {
    WIN_MIN_SEC   = 2'b00,
    WIN_WDAY_HOUR = 2'b01,
    WIN_MON_DAY   = 2'b10,
    WIN_YEAR      = 2'b11
  } win_sel_e;

  typedef struct packed {
    logic [7:0] year;
    logic [7:0] month;
    logic [7:0] day;
    logic [7:0] wday;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
  } rtc_time_t;

  localparam int unsigned CFG_EN_BIT   = 15;
  localparam int unsigned CFG_UNL_BIT  = 13;
  localparam int unsigned CFG_OE_BIT   = 10;
  localparam int unsigned CFG_PTR_LSB  = 8;

  localparam logic [7:0] WDAY_LAST = 8'h06;

  // Returns {wrap, next} for a two-digit BCD value that wraps after 'last'.
  function automatic logic [8:0] bcd_step(input logic [7:0] v, input logic [7:0] last);
    logic [8:0] r;
    if (v == last) begin
      r = 9'h100;
    end else if (v[3:0] >= 4'd9) begin
      r = {1'b0, v[7:4] + 4'd1, 4'd0};
    end else begin
      r = {1'b0, v[7:4], v[3:0] + 4'd1};
    end
    return r;
  endfunction

endpackage

// File: rtl/rtc_rst_sync.sv
module rtc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign srst_n = stage_q[1];

endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned TICKS_PER_SEC = 32768,
  parameter int unsigned SYNC_TICKS    = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic restart,
  output logic sec_stb,
  output logic half_sec,
  output logic sync_win
);

  localparam int unsigned CW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST_C      = CW'(TICKS_PER_SEC - 1);
  localparam logic [CW-1:0] HALF_C      = CW'(TICKS_PER_SEC / 2);
  localparam logic [CW-1:0] SYNC_FROM_C = CW'(TICKS_PER_SEC - SYNC_TICKS);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          stb_q, stb_d;
  logic          cnt_ce;
  logic          at_last;

  assign at_last = (cnt_q == LAST_C);
  assign cnt_ce  = restart | (en & tick);

  always_comb begin
    cnt_d = cnt_q;
    stb_d = 1'b0;
    if (restart) begin
      cnt_d = '0;
    end else if (en && tick) begin
      if (at_last) begin
        cnt_d = '0;
        stb_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= 1'b0;
    end else begin
      stb_q <= stb_d;
    end
  end

  assign sec_stb  = stb_q;
  assign half_sec = (cnt_q >= HALF_C);
  assign sync_win = (en & (cnt_q >= SYNC_FROM_C)) | stb_q;

  assert_wrap_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && !restart && at_last) |=> (sec_stb && cnt_q == '0));

  assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sec_stb |=> !sec_stb);

  assert_restart_clears_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !half_sec);

  assert_hold_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !restart) |=> ($stable(cnt_q) && !sec_stb));

endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_win_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic              wr_en,
  input  win_sel_e          wr_win,
  input  logic [15:0]       wr_data,
  output rtc_time_t         time_q
);

  rtc_time_t t_q, t_d;
  logic      t_ce;
  logic [8:0] sec_n, min_n, hour_n;

  assign t_ce = wr_en | upd;

  always_comb begin
    t_d    = t_q;
    sec_n  = bcd_step(t_q.sec,  8'h59);
    min_n  = bcd_step(t_q.min,  8'h59);
    hour_n = bcd_step(t_q.hour, 8'h23);
    if (wr_en) begin
      unique case (wr_win)
        WIN_MIN_SEC: begin
          t_d.min = wr_data[15:8];
          t_d.sec = wr_data[7:0];
        end
        WIN_WDAY_HOUR: begin
          t_d.wday = wr_data[15:8];
          t_d.hour = wr_data[7:0];
        end
        WIN_MON_DAY: begin
          t_d.month = wr_data[15:8];
          t_d.day   = wr_data[7:0];
        end
        WIN_YEAR: begin
          t_d.year = wr_data[7:0];
        end
        default: t_d = t_q;
      endcase
    end else if (upd) begin
      t_d.sec = sec_n[7:0];
      if (sec_n[8]) begin
        t_d.min = min_n[7:0];
        if (min_n[8]) begin
          t_d.hour = hour_n[7:0];
          if (hour_n[8]) begin
            t_d.wday = (t_q.wday >= WDAY_LAST) ? 8'h00 : t_q.wday + 8'h01;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q <= '0;
    end else if (t_ce) begin
      t_q <= t_d;
    end
  end

  assign time_q = t_q;

  assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && upd && wr_win == WIN_MIN_SEC) |=> (time_q.sec == $past(wr_data[7:0])));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !upd) |=> $stable(time_q));

  assert_sec_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !wr_en && time_q.sec == 8'h59) |=> (time_q.sec == 8'h00));

  assert_year_upper_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_win == WIN_YEAR) |=> ($stable(time_q.month) && $stable(time_q.min)));

endmodule

// File: rtl/rtc_cfg_reg.sv
module rtc_cfg_reg (
  input  logic        clk,
  input  logic        por_n,
  input  logic        cfg_wr,
  input  logic [15:0] cfg_wdata,
  input  logic        val_access,
  input  logic        half_sec,
  input  logic        sync_win,
  output logic [15:0] cfg_rdata,
  output logic        enable,
  output logic        unlock,
  output logic        out_en,
  output logic [1:0]  win_ptr
);

  import rtc_win_pkg::*;

  logic       en_q,  en_d;
  logic       unl_q, unl_d;
  logic       oe_q,  oe_d;
  logic [1:0] ptr_q, ptr_d;
  logic [7:0] cal_q, cal_d;
  logic       unused_wbits;

  assign unused_wbits = ^{cfg_wdata[14], cfg_wdata[12:11]};

  always_comb begin
    en_d  = en_q;
    unl_d = unl_q;
    oe_d  = oe_q;
    ptr_d = ptr_q;
    cal_d = cal_q;
    if (cfg_wr) begin
      unl_d = cfg_wdata[CFG_UNL_BIT];
      oe_d  = cfg_wdata[CFG_OE_BIT];
      ptr_d = cfg_wdata[CFG_PTR_LSB +: 2];
      cal_d = cfg_wdata[7:0];
      if (unl_q) begin
        en_d = cfg_wdata[CFG_EN_BIT];
      end
    end else if (val_access && ptr_q != 2'b00) begin
      ptr_d = ptr_q - 2'b01;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      en_q  <= 1'b0;
      unl_q <= 1'b0;
      oe_q  <= 1'b0;
      ptr_q <= 2'b00;
      cal_q <= 8'h00;
    end else begin
      en_q  <= en_d;
      unl_q <= unl_d;
      oe_q  <= oe_d;
      ptr_q <= ptr_d;
      cal_q <= cal_d;
    end
  end

  assign cfg_rdata = {en_q, 1'b0, unl_q, sync_win, half_sec, oe_q, ptr_q, cal_q};
  assign enable    = en_q;
  assign unlock    = unl_q;
  assign out_en    = oe_q;
  assign win_ptr   = ptr_q;

  assert_enable_locked_R4: assert property (@(posedge clk) disable iff (!por_n)
    (cfg_wr && !unl_q) |=> (en_q == $past(en_q)));

  assert_ptr_step_R1: assert property (@(posedge clk) disable iff (!por_n)
    (val_access && !cfg_wr && ptr_q != 2'b00) |=> (ptr_q == $past(ptr_q) - 2'b01));

  assert_ptr_floor_R1: assert property (@(posedge clk) disable iff (!por_n)
    (val_access && !cfg_wr && ptr_q == 2'b00) |=> (ptr_q == 2'b00));

  assert_cal_hold_R5: assert property (@(posedge clk) disable iff (!por_n)
    !cfg_wr |=> $stable(cal_q));

endmodule

// File: rtl/rtc_win_regs.sv
module rtc_win_regs #(
  parameter int unsigned TICKS_PER_SEC = 32768,
  parameter int unsigned SYNC_TICKS    = 32
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        cfg_wr,
  input  logic [15:0] cfg_wdata,
  output logic [15:0] cfg_rdata,
  input  logic        val_rd,
  input  logic        val_wr,
  input  logic [15:0] val_wdata,
  output logic [15:0] val_rdata,
  output logic        sec_out
);

  import rtc_win_pkg::*;

  logic       por_sync_n;
  logic       core_sync_n;
  logic       core_arst_n;
  logic       enable, unlock, out_en;
  logic [1:0] win_ptr;
  win_sel_e   win_sel;
  logic       sec_stb, half_sec, sync_win;
  logic       val_wr_ok;
  logic       restart;
  rtc_time_t  time_q;

  assign core_arst_n = por_n & rst_n;

  rtc_rst_sync u_por_sync (
    .clk    (clk),
    .arst_n (por_n),
    .srst_n (por_sync_n)
  );

  rtc_rst_sync u_core_sync (
    .clk    (clk),
    .arst_n (core_arst_n),
    .srst_n (core_sync_n)
  );

  assign win_sel   = win_sel_e'(win_ptr);
  assign val_wr_ok = val_wr & unlock;
  assign restart   = val_wr_ok & (win_sel == WIN_MIN_SEC);

  rtc_cfg_reg u_cfg (
    .clk        (clk),
    .por_n      (por_sync_n),
    .cfg_wr     (cfg_wr),
    .cfg_wdata  (cfg_wdata),
    .val_access (val_rd | val_wr),
    .half_sec   (half_sec),
    .sync_win   (sync_win),
    .cfg_rdata  (cfg_rdata),
    .enable     (enable),
    .unlock     (unlock),
    .out_en     (out_en),
    .win_ptr    (win_ptr)
  );

  rtc_prescaler #(
    .TICKS_PER_SEC (TICKS_PER_SEC),
    .SYNC_TICKS    (SYNC_TICKS)
  ) u_presc (
    .clk      (clk),
    .rst_n    (core_sync_n),
    .en       (enable),
    .tick     (tick_en),
    .restart  (restart),
    .sec_stb  (sec_stb),
    .half_sec (half_sec),
    .sync_win (sync_win)
  );

  rtc_time_core u_time (
    .clk     (clk),
    .rst_n   (core_sync_n),
    .upd     (sec_stb),
    .wr_en   (val_wr_ok),
    .wr_win  (win_sel),
    .wr_data (val_wdata),
    .time_q  (time_q)
  );

  always_comb begin
    unique case (win_sel)
      WIN_MIN_SEC:   val_rdata = {time_q.min,   time_q.sec};
      WIN_WDAY_HOUR: val_rdata = {time_q.wday,  time_q.hour};
      WIN_MON_DAY:   val_rdata = {time_q.month, time_q.day};
      WIN_YEAR:      val_rdata = {8'h00,        time_q.year};
      default:       val_rdata = 16'h0000;
    endcase
  end

  assign sec_out = out_en & half_sec;

  assert_locked_write_R3: assert property (@(posedge clk) disable iff (!core_sync_n)
    (val_wr && !unlock && !sec_stb) |=> $stable(time_q));

  assert_sec_out_R11: assert property (@(posedge clk) disable iff (!core_sync_n)
    !out_en |-> !sec_out);

endmodule

// File: tb/rtc_win_regs_tb.sv
module rtc_win_regs_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int TPS        = 8;
  localparam int SYNC_T     = 2;

  logic        clk = 1'b0;
  logic        por_n, rst_n, tick_en, cfg_wr, val_rd, val_wr;
  logic [15:0] cfg_wdata, val_wdata;
  logic [15:0] cfg_rdata, val_rdata;
  logic        sec_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_win_regs #(.TICKS_PER_SEC(TPS), .SYNC_TICKS(SYNC_T)) dut_i (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .tick_en(tick_en),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .val_rd(val_rd), .val_wr(val_wr), .val_wdata(val_wdata),
    .val_rdata(val_rdata), .sec_out(sec_out)
  );

  function automatic logic [15:0] mk_cfg(input logic en, input logic unl, input logic oe,
                                         input logic [1:0] ptr, input logic [7:0] cal);
    return {en, 1'b0, unl, 2'b00, oe, ptr, cal};
  endfunction

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_write(input logic [15:0] w);
    cfg_wr = 1'b1; cfg_wdata = w; cyc(); cfg_wr = 1'b0;
  endtask

  task automatic val_write(input logic [15:0] w);
    val_wr = 1'b1; val_wdata = w; cyc(); val_wr = 1'b0;
  endtask

  task automatic pulse(input int n);
    tick_en = 1'b1; cyc(n); tick_en = 1'b0; cyc(2);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] cal;
    por_n = 1'b0; rst_n = 1'b0; tick_en = 1'b0; cfg_wr = 1'b0; val_rd = 1'b0;
    val_wr = 1'b0; cfg_wdata = '0; val_wdata = '0;
    cyc(3);
    por_n = 1'b1; rst_n = 1'b1;
    cyc(4);
    // R10 reset state
    chk("R10 cfg after por", cfg_rdata, 16'h0000);
    chk("R10 time after por", val_rdata, 16'h0000);
    chk("R11 sec_out after por", {15'd0, sec_out}, 16'h0000);

    // R4/R5: locked enable, RO and unimplemented bits
    cfg_write(16'hFFFF);
    chk("R4 R5 locked all-ones write", cfg_rdata, 16'h27FF);
    cfg_write(16'hFFFF);
    chk("R4 R5 unlocked all-ones write", cfg_rdata, 16'hA7FF);

    // R3/R1: write sweep from pointer 3 down to 0
    val_write(16'hAB19);
    chk("R1 ptr after one write", {14'd0, cfg_rdata[9:8]}, 16'd2);
    val_write(16'h1228);
    val_write(16'h0521);
    val_write(16'h3045);
    chk("R1 ptr reached zero", {14'd0, cfg_rdata[9:8]}, 16'd0);
    cal = 8'h5A;
    cfg_write(mk_cfg(1'b1, 1'b1, 1'b1, 2'd3, cal));
    // R2 read sweep with strobes
    begin
      logic [15:0] exp_rd [5];
      exp_rd[0] = 16'h0019; exp_rd[1] = 16'h1228; exp_rd[2] = 16'h0521;
      exp_rd[3] = 16'h3045; exp_rd[4] = 16'h3045;
      for (int k = 0; k < 5; k++) begin
        val_rd = 1'b1;
        chk("R2 R3 window read", val_rdata, exp_rd[k]);
        cyc();
        val_rd = 1'b0;
        chk("R1 ptr step on read", {14'd0, cfg_rdata[9:8]}, 16'((k < 3) ? 2 - k : 0));
      end
    end

    // R1: config write beats pointer step in the same cycle
    cfg_wr = 1'b1; cfg_wdata = mk_cfg(1'b1, 1'b1, 1'b1, 2'd2, cal); val_rd = 1'b1;
    cyc(); cfg_wr = 1'b0; val_rd = 1'b0;
    chk("R1 cfg write wins over step", {14'd0, cfg_rdata[9:8]}, 16'd2);

    // R3: locked value write ignored, pointer still steps
    cfg_write(mk_cfg(1'b1, 1'b0, 1'b1, 2'd2, cal));
    val_write(16'h0101);
    chk("R3 locked write ptr step", {14'd0, cfg_rdata[9:8]}, 16'd1);
    chk("R3 locked write wday/hour", val_rdata, 16'h0521);
    cfg_write(mk_cfg(1'b0, 1'b0, 1'b1, 2'd2, cal));
    chk("R4 enable kept while locked", {15'd0, cfg_rdata[15]}, 16'd1);
    chk("R3 locked write mon/day", val_rdata, 16'h1228);
    cfg_write(mk_cfg(1'b1, 1'b1, 1'b1, 2'd0, cal));

    // R6 R7 R8 R11 timing within a second
    val_write(16'h0058);
    pulse(4);
    chk("R6 half-second set", {15'd0, cfg_rdata[11]}, 16'd1);
    chk("R11 sec_out high", {15'd0, sec_out}, 16'd1);
    chk("R7 sync low mid-second", {15'd0, cfg_rdata[12]}, 16'd0);
    pulse(2);
    chk("R7 sync high near rollover", {15'd0, cfg_rdata[12]}, 16'd1);
    pulse(2);
    chk("R8 seconds advance", val_rdata, 16'h0059);
    chk("R7 sync low after update", {15'd0, cfg_rdata[12]}, 16'd0);
    chk("R6 half-second low after wrap", {15'd0, cfg_rdata[11]}, 16'd0);
    pulse(8);
    chk("R8 minute carry", val_rdata, 16'h0100);
    val_write(16'h0130);
    pulse(5);
    val_write(16'h0130);
    chk("R6 write restarts prescaler", {15'd0, cfg_rdata[11]}, 16'd0);

    // R8 long sweep from 00:00
    val_write(16'h0000);
    for (int k = 1; k <= 125; k++) begin
      pulse(TPS);
      chk("R8 sweep min/sec", val_rdata, {to_bcd(k / 60), to_bcd(k % 60)});
    end

    // R8 hour and weekday wrap
    cfg_write(mk_cfg(1'b1, 1'b1, 1'b1, 2'd1, cal));
    val_write(16'h0623);
    val_write(16'h5959);
    pulse(TPS);
    chk("R8 min/sec wrap at day end", val_rdata, 16'h0000);
    cfg_write(mk_cfg(1'b1, 1'b1, 1'b1, 2'd1, cal));
    chk("R8 weekday 6 wraps to 0", val_rdata, 16'h0000);
    val_write(16'h0223);
    val_write(16'h5959);
    pulse(TPS);
    cfg_write(mk_cfg(1'b1, 1'b1, 1'b1, 2'd1, cal));
    chk("R8 weekday advance", val_rdata, 16'h0300);
    cfg_write(mk_cfg(1'b1, 1'b1, 1'b1, 2'd2, cal));
    chk("R3 mon/day untouched", val_rdata, 16'h1228);
    cfg_write(mk_cfg(1'b1, 1'b1, 1'b1, 2'd3, cal));
    chk("R3 year untouched", val_rdata, 16'h0019);

    // R8 disabled: no counting
    cfg_write(mk_cfg(1'b0, 1'b1, 1'b1, 2'd0, cal));
    val_write(16'h1234);
    pulse(2 * TPS);
    chk("R8 disabled holds time", val_rdata, 16'h1234);
    chk("R6 disabled half-second low", {15'd0, cfg_rdata[11]}, 16'd0);
    chk("R11 sec_out low", {15'd0, sec_out}, 16'd0);

    // R9 collision of write with the update
    cfg_write(mk_cfg(1'b1, 1'b1, 1'b1, 2'd0, cal));
    val_write(16'h0010);
    tick_en = 1'b1; cyc(TPS); tick_en = 1'b0;
    chk("R7 sync high in update cycle", {14'd0, cfg_rdata[12:11]}, 16'd2);
    val_write(16'h0520);
    cyc();
    chk("R9 write wins over update", val_rdata, 16'h0520);
    pulse(TPS);
    chk("R9 next second counts", val_rdata, 16'h0521);

    // R10 system reset keeps config
    rst_n = 1'b0; cyc(3); rst_n = 1'b1; cyc(4);
    chk("R10 cfg kept over rst_n", cfg_rdata, mk_cfg(1'b1, 1'b1, 1'b1, 2'd0, cal));
    chk("R10 time cleared by rst_n", val_rdata, 16'h0000);
    por_n = 1'b0; cyc(3); por_n = 1'b1; cyc(4);
    chk("R10 cfg cleared by por", cfg_rdata, 16'h0000);

    finish_run();
  end

endmodule